// File: doc/BRIEF.md
# Two-Stage Blocked Stream Reducer

This block folds a stream of signed integers into a single value with one of three operators: sum, minimum or maximum. A run is opened by a configuration handshake that carries the element count and the operator. The data stream then arrives with a valid/ready handshake and a flag on its final element. The result leaves through a third valid/ready handshake.

Work is split between two stages. The first stage cuts the stream into consecutive blocks of a fixed parameter length. Inside each block it spreads elements across several interleaved lane accumulators, so successive elements update different registers. When a block closes it folds the lanes into one partial and pushes it into a small on-chip FIFO. A short final block is padded with the operator identity. The second stage pops one partial per block into a ring of slot accumulators, which stands in for a pipelined combiner with several cycles of latency. Once it has taken the expected number of partials it folds the slots and presents the result. A new run is accepted only after the previous result has been taken.

Top module: `blk_reduce`

## Requirements
- R1: `cfg_ready_o` is high after reset. It goes low in the cycle after a configuration is accepted and stays low while a run is open or its result is waiting.
- R2: With `cfg_op_i` = 2'b00, the result equals the 32-bit wrapping sum of the sign-extended input elements, taken in order.
- R3: With `cfg_op_i` = 2'b01, the result equals the smallest input element as a signed value, sign-extended to 32 bits.
- R4: With `cfg_op_i` = 2'b10, the result equals the largest input element as a signed value, sign-extended to 32 bits. Code 2'b11 behaves as a sum.
- R5: When the length is not a multiple of the block length, the result is the same as for a plain sequential fold. This includes a length of one, a length shorter than one block, and a length one past a block boundary.
- R6: `in_ready_o` is low whenever no run is open. Beats offered while idle are not taken and do not change the next result.
- R7: No partial is written into a full FIFO or read from an empty one. Runs with more blocks than the FIFO depth give the correct result.
- R8: Once `res_valid_o` is high it stays high, with `res_data_o` unchanged, until `res_ready_i` takes it.
- R9: Idle cycles between input beats do not change the result.
- R10: In the cycle after the result is taken, `cfg_ready_o` is high again. Each run starts from fresh state, independent of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Configuration offered |
| cfg_ready_o | output | 1 | Block idle, configuration taken |
| cfg_len_i | input | LEN_W | Number of elements in the run (at least 1) |
| cfg_op_i | input | 2 | Operator: 00 sum, 01 min, 10 max, 11 sum |
| in_valid_i | input | 1 | Input beat offered |
| in_ready_o | output | 1 | Input beat taken |
| in_data_i | input | DATA_W | Signed input element |
| in_last_i | input | 1 | Marks the final element of the run |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result taken |
| res_data_o | output | 32 | Signed reduced value |

## Verification
The bench uses a small build: four elements per block, two lanes, two slots and a two-entry FIFO. With that build it sweeps every operator code over all lengths from one to thirteen. This crosses a single element, part of a block, exact block multiples and lengths one past a boundary, so padding faults separate from lane or slot faults. Element values span the full signed 16-bit range, which exposes sign-extension and comparison errors that small positive values would hide. Some runs insert idle beats or hold the result unaccepted, to separate handshake faults from arithmetic ones. A ten-block run overfills the FIFO depth, and stray beats are offered before any configuration.

// File: rtl/red_pkg.sv
package red_pkg;
  localparam int unsigned RED_ACC_W = 32;

  typedef logic signed [RED_ACC_W-1:0] acc_t;

  typedef enum logic [1:0] {
    OP_SUM  = 2'b00,
    OP_MIN  = 2'b01,
    OP_MAX  = 2'b10,
    OP_SUM2 = 2'b11
  } red_op_e;

  function automatic acc_t red_ident(red_op_e op);
    case (op)
      OP_MIN:  return {1'b0, {(RED_ACC_W-1){1'b1}}};
      OP_MAX:  return {1'b1, {(RED_ACC_W-1){1'b0}}};
      default: return '0;
    endcase
  endfunction

  function automatic acc_t red_apply(red_op_e op, acc_t a, acc_t b);
    case (op)
      OP_MIN:  return (a < b) ? a : b;
      OP_MAX:  return (a > b) ? a : b;
      default: return a + b;
    endcase
  endfunction
endpackage

// File: rtl/red_fifo.sv
module red_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [AW:0]      cnt_q;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop_i)  rptr_q <= rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/red_block_stage.sv
module red_block_stage
  import red_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BLK_LEN = 32,
  parameter int unsigned LANES   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic              fifo_full_i,
  output logic              push_o,
  output acc_t              partial_o,
  output logic              active_o
);
  localparam int unsigned BLK_W  = $clog2(BLK_LEN);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic             active_q, flush_q, fin_q;
  red_op_e          op_q;
  logic [BLK_W-1:0] cnt_q;
  logic             accept, blk_end;
  logic [LANE_W-1:0] lane_idx;
  acc_t             din_ext;
  acc_t             lane_val [LANES];

  assign in_ready_o = active_q & ~flush_q;
  assign accept     = in_valid_i & in_ready_o;
  assign blk_end    = accept & (in_last_i | (cnt_q == BLK_W'(BLK_LEN-1)));
  assign push_o     = flush_q & ~fifo_full_i;
  assign active_o   = active_q;
  assign lane_idx   = cnt_q[LANE_W-1:0];
  assign din_ext    = {{(RED_ACC_W-DATA_W){in_data_i[DATA_W-1]}}, in_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      flush_q  <= 1'b0;
      fin_q    <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_SUM;
    end else if (start_i) begin
      active_q <= 1'b1;
      flush_q  <= 1'b0;
      fin_q    <= 1'b0;
      cnt_q    <= '0;
      op_q     <= red_op_e'(op_i);
    end else begin
      if (accept) cnt_q <= cnt_q + 1'b1;
      if (blk_end) begin
        flush_q <= 1'b1;
        fin_q   <= in_last_i;
      end
      if (push_o) begin
        flush_q <= 1'b0;
        cnt_q   <= '0;
        if (fin_q) active_q <= 1'b0;
      end
    end
  end

  // interleaved lanes: consecutive elements land in different accumulators
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    acc_t acc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                acc_q <= '0;
      else if (start_i)                           acc_q <= red_ident(red_op_e'(op_i));
      else if (push_o)                            acc_q <= red_ident(op_q);
      else if (accept && lane_idx == LANE_W'(l))  acc_q <= red_apply(op_q, acc_q, din_ext);
    end
    assign lane_val[l] = acc_q;
  end

  always_comb begin
    partial_o = red_ident(op_q);
    for (int l = 0; l < LANES; l++) partial_o = red_apply(op_q, partial_o, lane_val[l]);
  end
endmodule

// File: rtl/red_final_stage.sv
module red_final_stage
  import red_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [LEN_W-1:0] nblk_i,
  input  logic             empty_i,
  input  acc_t             part_i,
  output logic             pop_o,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output acc_t             res_o,
  output logic             idle_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  typedef enum logic [1:0] {S2_IDLE, S2_ACC, S2_DONE} phase_e;

  phase_e            phase_q;
  red_op_e           op_q;
  logic [LEN_W-1:0]  nblk_q, got_q;
  logic [SLOT_W-1:0] ptr_q;
  acc_t              slot_q [SLOTS];

  assign pop_o       = (phase_q == S2_ACC) & ~empty_i;
  assign res_valid_o = (phase_q == S2_DONE);
  assign idle_o      = (phase_q == S2_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= S2_IDLE;
      op_q    <= OP_SUM;
      nblk_q  <= '0;
      got_q   <= '0;
      ptr_q   <= '0;
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
    end else if (start_i) begin
      phase_q <= S2_ACC;
      op_q    <= red_op_e'(op_i);
      nblk_q  <= nblk_i;
      got_q   <= '0;
      ptr_q   <= '0;
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= red_ident(red_op_e'(op_i));
    end else begin
      case (phase_q)
        S2_ACC: if (pop_o) begin
          // rotate slots: each slot sees a new partial only every SLOTS pops
          slot_q[ptr_q] <= red_apply(op_q, slot_q[ptr_q], part_i);
          ptr_q         <= ptr_q + 1'b1;
          got_q         <= got_q + 1'b1;
          if (got_q + 1'b1 == nblk_q) phase_q <= S2_DONE;
        end
        S2_DONE: if (res_ready_i) phase_q <= S2_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    res_o = red_ident(op_q);
    for (int s = 0; s < SLOTS; s++) res_o = red_apply(op_q, res_o, slot_q[s]);
  end
endmodule

// File: rtl/blk_reduce.sv
module blk_reduce
  import red_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned BLK_LEN    = 32,
  parameter int unsigned LANES      = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned SLOTS      = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_valid_i,
  output logic                 cfg_ready_o,
  input  logic [LEN_W-1:0]     cfg_len_i,
  input  logic [1:0]           cfg_op_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [DATA_W-1:0]    in_data_i,
  input  logic                 in_last_i,
  output logic                 res_valid_o,
  input  logic                 res_ready_i,
  output logic [RED_ACC_W-1:0] res_data_o
);
  localparam int unsigned BLK_LOG = $clog2(BLK_LEN);
  localparam int unsigned EXT_W   = LEN_W + 1;

  logic             start, s1_active, s2_idle;
  logic             s1_push, s2_pop, fifo_full, fifo_empty;
  acc_t             s1_partial, fifo_rdata, s2_res;
  logic [EXT_W-1:0] len_round;
  logic [LEN_W-1:0] nblk;

  assign cfg_ready_o = s2_idle & ~s1_active;
  assign start       = cfg_valid_i & cfg_ready_o;
  assign len_round   = EXT_W'(cfg_len_i) + EXT_W'(BLK_LEN-1);
  assign nblk        = LEN_W'(len_round >> BLK_LOG);
  assign res_data_o  = s2_res;

  red_block_stage #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN), .LANES(LANES)) u_stage1 (
    .clk_i, .rst_ni,
    .start_i     (start),
    .op_i        (cfg_op_i),
    .in_valid_i,
    .in_data_i,
    .in_last_i,
    .in_ready_o,
    .fifo_full_i (fifo_full),
    .push_o      (s1_push),
    .partial_o   (s1_partial),
    .active_o    (s1_active)
  );

  red_fifo #(.WIDTH(RED_ACC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (s1_push),
    .wdata_i (s1_partial),
    .pop_i   (s2_pop),
    .rdata_o (fifo_rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  red_final_stage #(.LEN_W(LEN_W), .SLOTS(SLOTS)) u_stage2 (
    .clk_i, .rst_ni,
    .start_i     (start),
    .op_i        (cfg_op_i),
    .nblk_i      (nblk),
    .empty_i     (fifo_empty),
    .part_i      (fifo_rdata),
    .pop_o       (s2_pop),
    .res_valid_o,
    .res_ready_i,
    .res_o       (s2_res),
    .idle_o      (s2_idle)
  );
endmodule

// File: rtl/blk_reduce_chk.sv
module blk_reduce_chk #(
  parameter int unsigned RES_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_ready_o,
  input logic             in_ready_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [RES_W-1:0] res_data_o,
  input logic             push,
  input logic             fifo_full,
  input logic             pop,
  input logic             fifo_empty
);
  assert_busy_while_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !cfg_ready_o);

  assert_no_input_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ready_o |-> !in_ready_o);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push && fifo_full));

  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop && fifo_empty));

  assert_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  assert_ready_after_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i) |=> cfg_ready_o);
endmodule

bind blk_reduce blk_reduce_chk #(.RES_W(red_pkg::RED_ACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_ready_o (cfg_ready_o),
  .in_ready_o  (in_ready_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_data_o  (res_data_o),
  .push        (s1_push),
  .fifo_full   (fifo_full),
  .pop         (s2_pop),
  .fifo_empty  (fifo_empty)
);

// File: tb/blk_reduce_bench.sv
`timescale 1ns/1ps
module blk_reduce_bench;
  localparam int BLK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, cfg_ready;
  logic [15:0] cfg_len = '0;
  logic [1:0]  cfg_op = '0;
  logic        in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [15:0] in_data = '0;
  logic        res_valid, res_ready = 1'b0;
  logic [31:0] res_data;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  blk_reduce #(.DATA_W(16), .LEN_W(16), .BLK_LEN(BLK), .LANES(2), .FIFO_DEPTH(2), .SLOTS(2))
  u_blk_reduce (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_ready_o(cfg_ready), .cfg_len_i(cfg_len), .cfg_op_i(cfg_op),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_data_o(res_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dval(int k, int seed);
    return ((k * 7919 + seed * 104729 + 12345) % 65536) - 32768;
  endfunction

  function automatic int ref_fold(int op, int len, int seed);
    int acc;
    acc = (op == 1) ? 32'h7fffffff : (op == 2) ? 32'h80000000 : 0;
    for (int k = 0; k < len; k++) begin
      int v;
      v = dval(k, seed);
      if (op == 1)      acc = (v < acc) ? v : acc;
      else if (op == 2) acc = (v > acc) ? v : acc;
      else              acc = acc + v;
    end
    return acc;
  endfunction

  task automatic do_run(input int op, input int len, input int seed, input bit gaps,
                        input bit hold, input string tag);
    int exp, held;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_len = 16'(len); cfg_op = 2'(op);
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    check(cfg_ready == 1'b0, "R1 busy after config", int'(cfg_ready), 0);
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1; in_data = 16'(dval(k, seed)); in_last = (k == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (gaps && (k % 3 == 1)) repeat (2) @(negedge clk);
    end
    while (!res_valid) @(negedge clk);
    exp = ref_fold(op, len, seed);
    if (hold) begin
      held = int'(res_data);
      repeat (5) @(negedge clk);
      check(res_valid && int'(res_data) == held, "R8 result held", int'(res_data), held);
    end
    check(int'(res_data) == exp, tag, int'(res_data), exp);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(cfg_ready == 1'b1, "R10 idle after take", int'(cfg_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_ready == 1'b1, "R1 reset cfg_ready", int'(cfg_ready), 1);
    check(res_valid == 1'b0, "R8 reset res_valid", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: beats offered while idle are refused
    in_valid = 1'b1; in_data = 16'h7fff; in_last = 1'b1;
    for (int c = 0; c < 3; c++) begin
      check(in_ready == 1'b0, "R6 idle refuses input", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    do_run(0, 3, 7, 1'b0, 1'b0, "R6 result unaffected by idle beats");

    for (int op = 0; op < 4; op++) begin
      for (int len = 1; len <= 13; len++) begin
        string tag;
        if (len % BLK != 0)  tag = $sformatf("R5 op=%0d len=%0d", op, len);
        else if (op == 1)    tag = $sformatf("R3 min len=%0d", len);
        else if (op == 2)    tag = $sformatf("R4 max len=%0d", len);
        else                 tag = $sformatf("R2 sum op=%0d len=%0d", op, len);
        do_run(op, len, op * 31 + len, 1'b0, (len % 5 == 0), tag);
      end
    end
    for (int op = 0; op < 3; op++) begin
      do_run(op, 11, 90 + op, 1'b1, 1'b0, $sformatf("R9 gaps op=%0d", op));
      do_run(op, 40, 60 + op, 1'b0, 1'b0, $sformatf("R7 ten blocks op=%0d", op));
    end
    do_run(3, 8, 5, 1'b1, 1'b1, "R4 code 11 sums");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule